// File: doc/BRIEF.md
# Streaming Hamming ECC Generator

The block sits beside a byte-wide data stream and builds Hamming parity codes over fixed-size blocks of that stream as the bytes go past. Every cycle in which the byte strobe is high, one byte is folded into a running set of parities. When a block is complete, its 24-bit code is written to a result register and a done flag for that register goes high. With this code, a later reader can locate and correct any single flipped bit in the block, and can detect any pair of flipped bits.

A mode input chooses between two block layouts. Mode 0 splits 512 bytes into two 256-byte halves and gives each half its own code, one in each result register. Mode 1 covers all 512 bytes with one code in the first result register. After the last code of the chosen layout is stored, both result registers hold their values until a restart strobe arrives. The restart strobe clears the byte count, the partial parities, the results and the done flags. The mode input must stay constant from one restart to the completion of the last code.

Each code holds two kinds of parity. Column parities cover bit positions inside the byte. Line parities cover the byte's index inside its block. Both are kept as even/odd pairs, so a single-bit error flips exactly one bit of every pair.

Top module: `ecc_stream_gen`

## Requirements
- R1: After the asynchronous reset, both result outputs read 24'hFFFFFF and both done flags are 0.
- R2: Code bits [5:0] hold the column parities. For j = 0, 1, 2, bit 2j is the XOR over all block bytes of the data bits whose bit index has bit j equal to 0, and bit 2j+1 is the same XOR for bit index bit j equal to 1.
- R3: For byte-index bit k, code bit 6+2k is the XOR of all data bits of the block bytes whose in-block index has bit k equal to 0, and code bit 7+2k is the same XOR for index bit k equal to 1. Here k runs 0..7 for a 256-byte block and 0..8 for a 512-byte block.
- R4: In mode 0, the clock edge that takes the 256th accepted byte stores the first half's code in ecc1_o and sets done1_o. The edge that takes the 512th accepted byte stores the second half's code in ecc2_o and sets done2_o. Code bits [23:22] of a 256-byte code are 1, and the second half's parities start from zero.
- R5: In mode 1, ecc1_o and done1_o do not change before the 512th accepted byte. The edge that takes that byte stores the 24-bit code in ecc1_o and sets done1_o. ecc2_o stays 24'hFFFFFF and done2_o stays 0.
- R6: Once the final code of the selected mode is stored, further bytes change neither result output nor either done flag until the next restart strobe.
- R7: A cycle with the byte strobe low consumes no byte, whatever value is on the data input.
- R8: The restart strobe returns both results to 24'hFFFFFF and both done flags to 0 on the next edge, and the next accepted byte becomes byte 0 of a fresh calculation.
- R9: When the restart strobe and the byte strobe are high in the same cycle, the restart wins and that byte is not counted.
- R10: The XOR of a stored code with the code of a copy of the data carrying one flipped bit has exactly one bit set in every pair. Its odd bits give the byte index and the bit index of the flipped bit. Two flipped bits give a nonzero syndrome that does not have this form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Restart strobe; starts a new calculation |
| mode_i | input | 1 | 0: two 256-byte codes, 1: one 512-byte code |
| valid_i | input | 1 | Byte strobe; one byte consumed per high cycle |
| data_i | input | 8 | Stream byte |
| ecc1_o | output | 24 | First result register |
| ecc2_o | output | 24 | Second result register |
| done1_o | output | 1 | ecc1_o holds a completed code |
| done2_o | output | 1 | ecc2_o holds a completed code |

## Verification
The restart strobe and the byte strobe can be high in the same cycle. The bench provokes this by raising both together, then sending 255 further bytes. If the colliding byte had been counted, the first code would complete one byte early. So the bench expects done1_o to be still low after those 255 bytes, to rise only on the 256th, and ecc1_o to equal the code of just the 256 bytes sent after the restart.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int BYTE_W     = 8;
  localparam int BIT_AW     = $clog2(BYTE_W);
  localparam int COL_W      = 2 * BIT_AW;
  localparam int BLK_AW_DEF = 8;

  // even/odd column parity contribution of one byte
  function automatic logic [COL_W-1:0] col_contrib(input logic [BYTE_W-1:0] b);
    logic [COL_W-1:0] c;
    c = '0;
    for (int j = 0; j < BIT_AW; j++) begin
      for (int t = 0; t < BYTE_W; t++) begin
        if (t[j]) c[2*j+1] = c[2*j+1] ^ b[t];
        else      c[2*j]   = c[2*j]   ^ b[t];
      end
    end
    return c;
  endfunction
endpackage

// File: rtl/ecc_col_acc.sv
module ecc_col_acc
  import ecc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              restart_i,
  input  logic              en_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [COL_W-1:0]  col_nxt_o,
  output logic              par_o
);
  logic [COL_W-1:0] col_q;
  logic [COL_W-1:0] contrib;

  always_comb begin
    contrib = col_contrib(data_i);
    par_o   = ^data_i;
  end

  assign col_nxt_o = en_i ? (col_q ^ contrib) : col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 col_q <= '0;
    else if (clr_i || restart_i) col_q <= '0;
    else if (en_i)               col_q <= col_q ^ contrib;
  end
endmodule

// File: rtl/ecc_line_acc.sv
module ecc_line_acc #(
  parameter int Aw = 9
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            restart_i,
  input  logic            en_i,
  input  logic [Aw-1:0]   bit_en_i,
  input  logic [Aw-1:0]   idx_i,
  input  logic            par_i,
  output logic [2*Aw-1:0] lp_nxt_o
);
  for (genvar k = 0; k < Aw; k++) begin : g_line
    logic ev_q, od_q;
    logic hit;

    assign hit = en_i && bit_en_i[k] && par_i;
    assign lp_nxt_o[2*k]   = ev_q ^ (hit && !idx_i[k]);
    assign lp_nxt_o[2*k+1] = od_q ^ (hit && idx_i[k]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ev_q <= 1'b0;
        od_q <= 1'b0;
      end else if (clr_i || restart_i) begin
        ev_q <= 1'b0;
        od_q <= 1'b0;
      end else begin
        ev_q <= lp_nxt_o[2*k];
        od_q <= lp_nxt_o[2*k+1];
      end
    end
  end
endmodule

// File: rtl/ecc_seq_ctrl.sv
module ecc_seq_ctrl #(
  parameter int BlkAw = 8,
  localparam int LineAw = BlkAw + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              mode_i,
  input  logic              valid_i,
  output logic              take_o,
  output logic [LineAw-1:0] idx_o,
  output logic              store1_o,
  output logic              store2_o,
  output logic              done1_o,
  output logic              done2_o
);
  logic [LineAw-1:0] cnt_q;
  logic              done1_q, done2_q;
  logic              frozen, half_end, upper;

  assign frozen   = done2_q || (done1_q && mode_i);
  assign take_o   = valid_i && !clr_i && !frozen;
  assign half_end = &cnt_q[BlkAw-1:0];
  assign upper    = cnt_q[BlkAw];
  assign store1_o = take_o && half_end && (mode_i ? upper : !upper);
  assign store2_o = take_o && half_end && upper && !mode_i;
  assign idx_o    = cnt_q;
  assign done1_o  = done1_q;
  assign done2_o  = done2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      done1_q <= 1'b0;
      done2_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      done1_q <= 1'b0;
      done2_q <= 1'b0;
    end else begin
      if (take_o)   cnt_q   <= cnt_q + 1'b1;
      if (store1_o) done1_q <= 1'b1;
      if (store2_o) done2_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ecc_stream_gen.sv
module ecc_stream_gen #(
  parameter int BlkAw = ecc_pkg::BLK_AW_DEF,
  localparam int LineAw = BlkAw + 1,
  localparam int CodeW  = ecc_pkg::COL_W + 2 * LineAw
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      mode_i,
  input  logic                      valid_i,
  input  logic [ecc_pkg::BYTE_W-1:0] data_i,
  output logic [CodeW-1:0]          ecc1_o,
  output logic [CodeW-1:0]          ecc2_o,
  output logic                      done1_o,
  output logic                      done2_o
);
  import ecc_pkg::*;

  logic              take, store1, store2, par;
  logic [LineAw-1:0] idx;
  logic [COL_W-1:0]  col_nxt;
  logic [2*LineAw-1:0] lp_nxt;
  logic [LineAw-1:0] bit_en;
  logic [CodeW-1:0]  code_nxt;
  logic [CodeW-1:0]  ecc1_q, ecc2_q;

  ecc_seq_ctrl #(.BlkAw(BlkAw)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_i),
    .mode_i   (mode_i),
    .valid_i  (valid_i),
    .take_o   (take),
    .idx_o    (idx),
    .store1_o (store1),
    .store2_o (store2),
    .done1_o  (done1_o),
    .done2_o  (done2_o)
  );

  ecc_col_acc u_col (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .restart_i (store1),
    .en_i      (take),
    .data_i    (data_i),
    .col_nxt_o (col_nxt),
    .par_o     (par)
  );

  // top index bit only counts for the long block
  assign bit_en = {mode_i, {BlkAw{1'b1}}};

  ecc_line_acc #(.Aw(LineAw)) u_line (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .restart_i (store1),
    .en_i      (take),
    .bit_en_i  (bit_en),
    .idx_i     (idx),
    .par_i     (par),
    .lp_nxt_o  (lp_nxt)
  );

  assign code_nxt = {mode_i ? lp_nxt[2*LineAw-1 -: 2] : 2'b11,
                     lp_nxt[2*BlkAw-1:0], col_nxt};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ecc1_q <= '1;
      ecc2_q <= '1;
    end else if (clr_i) begin
      ecc1_q <= '1;
      ecc2_q <= '1;
    end else begin
      if (store1) ecc1_q <= code_nxt;
      if (store2) ecc2_q <= code_nxt;
    end
  end

  assign ecc1_o = ecc1_q;
  assign ecc2_o = ecc2_q;
endmodule

// File: rtl/ecc_stream_gen_chk.sv
module ecc_stream_gen_chk #(
  parameter int CodeW = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             mode_i,
  input logic             valid_i,
  input logic [CodeW-1:0] ecc1_o,
  input logic [CodeW-1:0] ecc2_o,
  input logic             done1_o,
  input logic             done2_o
);
  assert_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (ecc1_o == '1) && (ecc2_o == '1) && !done1_o && !done2_o);

  assert_ecc2_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done2_o |-> (ecc2_o == '1));

  assert_pad_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done2_o |-> (ecc2_o[CodeW-1 -: 2] == 2'b11));

  assert_done_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done2_o) |-> done1_o);

  assert_no_done2_long_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done2_o) |-> !$past(mode_i));

  assert_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done2_o || (done1_o && mode_i)) && !clr_i |=>
      $stable(ecc1_o) && $stable(ecc2_o) && $stable(done1_o) && $stable(done2_o));

  assert_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i && !clr_i |=>
      $stable(ecc1_o) && $stable(ecc2_o) && $stable(done1_o) && $stable(done2_o));
endmodule

bind ecc_stream_gen ecc_stream_gen_chk #(.CodeW(CodeW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clr_i   (clr_i),
  .mode_i  (mode_i),
  .valid_i (valid_i),
  .ecc1_o  (ecc1_o),
  .ecc2_o  (ecc2_o),
  .done1_o (done1_o),
  .done2_o (done2_o)
);

// File: tb/ecc_stream_gen_tb.sv
module ecc_stream_gen_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr_i = 1'b0;
  logic        mode_i = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  data_i = 8'h00;
  logic [23:0] ecc1_o, ecc2_o;
  logic        done1_o, done2_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] mem [0:511];

  always #2.5 clk_i = ~clk_i;

  ecc_stream_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .mode_i(mode_i),
    .valid_i(valid_i), .data_i(data_i), .ecc1_o(ecc1_o), .ecc2_o(ecc2_o),
    .done1_o(done1_o), .done2_o(done2_o)
  );

  task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] model(int base, int aw);
    logic [5:0]  col = '0;
    logic [17:0] lp = '0;
    logic [23:0] c = '1;
    for (int i = 0; i < (1 << aw); i++) begin
      logic [7:0] b = mem[base+i];
      for (int t = 0; t < 8; t++)
        if (b[t]) for (int j = 0; j < 3; j++) col[2*j + ((t >> j) & 1)] ^= 1'b1;
      for (int k = 0; k < aw; k++) lp[2*k + ((i >> k) & 1)] ^= ^b;
    end
    c[5:0] = col;
    for (int m = 0; m < 2*aw; m++) c[6+m] = lp[m];
    return c;
  endfunction

  task automatic push(logic [7:0] b);
    data_i = b; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0; data_i = 8'h5A;
  endtask

  task automatic push_range(int base, int n);
    for (int i = 0; i < n; i++) push(mem[base+i]);
  endtask

  task automatic restart(logic m);
    mode_i = m; clr_i = 1'b1;
    @(negedge clk_i);
    clr_i = 1'b0;
  endtask

  task automatic fill_rand();
    for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
  endtask

  task automatic t_reset();
    chk("R1 ecc1", ecc1_o, 24'hFFFFFF);
    chk("R1 ecc2", ecc2_o, 24'hFFFFFF);
    chk("R1 done", {22'd0, done2_o, done1_o}, 24'd0);
  endtask

  task automatic t_pattern();
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    mem[0] = 8'h01; mem[511] = 8'h80;
    restart(1'b0);
    push_range(0, 512);
    chk("R2 R3 single low byte", ecc1_o, 24'hD55555);
    chk("R2 R3 R4 single high byte, second half restarts", ecc2_o, 24'hEAAAAA);
  endtask

  task automatic t_mode0();
    fill_rand();
    restart(1'b0);
    push_range(0, 255);
    chk("R4 no done1 before byte 256", {23'd0, done1_o}, 24'd0);
    push(mem[255]);
    chk("R4 ecc1", ecc1_o, model(0, 8));
    chk("R4 flags after half", {22'd0, done2_o, done1_o}, 24'd1);
    chk("R4 ecc2 untouched", ecc2_o, 24'hFFFFFF);
    push_range(256, 256);
    chk("R4 ecc2", ecc2_o, model(256, 8));
    chk("R4 ecc1 kept", ecc1_o, model(0, 8));
    chk("R4 flags after full", {22'd0, done2_o, done1_o}, 24'd3);
  endtask

  task automatic t_mode1();
    logic [23:0] exp;
    fill_rand();
    exp = model(0, 9);
    restart(1'b1);
    push_range(0, 511);
    chk("R5 ecc1 unchanged before 512", ecc1_o, 24'hFFFFFF);
    chk("R5 done1 low before 512", {23'd0, done1_o}, 24'd0);
    push(mem[511]);
    chk("R5 R3 ecc1 long", ecc1_o, exp);
    chk("R5 ecc2 unused", ecc2_o, 24'hFFFFFF);
    chk("R5 flags", {22'd0, done2_o, done1_o}, 24'd1);
    for (int i = 0; i < 40; i++) push(8'($urandom));
    chk("R6 long frozen ecc1", ecc1_o, exp);
    chk("R6 long frozen flags", {22'd0, done2_o, done1_o}, 24'd1);
  endtask

  task automatic t_freeze();
    logic [23:0] e1, e2;
    fill_rand();
    e1 = model(0, 8); e2 = model(256, 8);
    restart(1'b0);
    push_range(0, 512);
    for (int i = 0; i < 300; i++) push(8'($urandom));
    chk("R6 ecc1 frozen", ecc1_o, e1);
    chk("R6 ecc2 frozen", ecc2_o, e2);
    chk("R6 flags frozen", {22'd0, done2_o, done1_o}, 24'd3);
  endtask

  task automatic t_gaps();
    fill_rand();
    restart(1'b0);
    for (int i = 0; i < 256; i++) begin
      push(mem[i]);
      for (int g = 0; g < (i % 3); g++) begin
        data_i = 8'($urandom);
        @(negedge clk_i);
      end
    end
    chk("R7 idle cycles ignored", ecc1_o, model(0, 8));
    chk("R7 count exact", {22'd0, done2_o, done1_o}, 24'd1);
  endtask

  task automatic t_clr_mid();
    fill_rand();
    restart(1'b0);
    for (int i = 0; i < 300; i++) push(8'($urandom));
    restart(1'b0);
    chk("R8 ecc1 cleared", ecc1_o, 24'hFFFFFF);
    chk("R8 flags cleared", {22'd0, done2_o, done1_o}, 24'd0);
    push_range(0, 256);
    chk("R8 fresh calculation", ecc1_o, model(0, 8));
  endtask

  task automatic t_collide();
    fill_rand();
    restart(1'b0);
    for (int i = 0; i < 50; i++) push(8'($urandom));
    clr_i = 1'b1; valid_i = 1'b1; data_i = 8'hA7;
    @(negedge clk_i);
    clr_i = 1'b0; valid_i = 1'b0;
    push_range(0, 255);
    chk("R9 colliding byte not counted", {23'd0, done1_o}, 24'd0);
    push(mem[255]);
    chk("R9 code of bytes after restart", ecc1_o, model(0, 8));
  endtask

  task automatic t_correct(logic m, int aw, int by, int bt);
    logic [23:0] good, s;
    int pairs, loc_byte, loc_bit;
    bit single;
    fill_rand();
    good = model(0, aw);
    mem[by][bt] = ~mem[by][bt];
    restart(m);
    push_range(0, 1 << aw);
    s = good ^ ecc1_o;
    pairs = 3 + aw; single = 1; loc_byte = 0; loc_bit = 0;
    for (int p = 0; p < pairs; p++) if (!(s[2*p] ^ s[2*p+1])) single = 0;
    for (int j = 0; j < 3; j++) loc_bit |= int'(s[2*j+1]) << j;
    for (int k = 0; k < aw; k++) loc_byte |= int'(s[7+2*k]) << k;
    chk("R10 single syndrome form", {23'd0, single}, 24'd1);
    chk("R10 byte located", 24'(loc_byte), 24'(by));
    chk("R10 bit located", 24'(loc_bit), 24'(bt));
    mem[by][bt] = ~mem[by][bt];
    mem[(by + 3) % (1 << aw)][(bt + 1) % 8] ^= 1'b1;
    mem[by][bt] = ~mem[by][bt];
    restart(m);
    push_range(0, 1 << aw);
    s = good ^ ecc1_o;
    single = 1;
    for (int p = 0; p < pairs; p++) if (!(s[2*p] ^ s[2*p+1])) single = 0;
    chk("R10 double detected", {23'd0, (s != 0) && !single}, 24'd1);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk_i);
      if (finished) break;
    end
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_pattern();
    t_mode0();
    t_mode1();
    restart(1'b0);
    t_freeze();
    t_gaps();
    t_clr_mid();
    t_collide();
    t_correct(1'b0, 8, 37, 5);
    restart(1'b1);
    t_correct(1'b1, 9, 400, 2);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule